// File: doc/BRIEF.md
# VPS Line-16 Bi-phase Label Decoder

This block recovers the programme label carried in the dedicated data line of the vertical blanking interval. A sliced one-bit video data stream arrives together with a sample strobe that fires twice per data bit. The strobe comes from a regenerated 10 MHz clock. A gate input marks the active part of TV line 16. Only while that gate is high does the decoder look at the stream.

Inside each gated line the decoder first hunts for the clock run-in and start code. It does this by matching the most recent raw half-bit samples against a fixed pattern. Once the pattern has been seen, the decoder pairs the following half-bit samples into bi-phase symbols and packs them into bytes, most significant bit first. It flags any symbol whose two halves are equal. Six of the twelve data bytes form the label. These are kept in a shadow store and copied into a transfer register only when the whole line decoded cleanly and the host side is not reading at that moment. An active-low data-available flag is released at the start of each line and pulled low when a clean line is committed.

Top module: `vps_line_decoder`

## Requirements
- R1: After reset, `davn_n` is 1 and `xfer_data` is all zeros.
- R2: Data bytes are decoded only after the last 24 raw half-bit samples of the line equal the start pattern 24'hAAAA59 (oldest sample in the MSB). A line in which the pattern never appears leaves `xfer_data` unchanged and `davn_n` high.
- R3: A half-bit pair of 1 then 0 decodes to bit 1, and a pair of 0 then 1 decodes to bit 0. The eight bits of each byte arrive most significant first.
- R4: A symbol with two equal halves in any of the twelve data bytes, including bytes that are not stored, blocks the commit for that line: `xfer_data` is kept and `davn_n` stays high.
- R5: Line bytes are numbered so that the first byte after the start pattern is byte 4. A committed line places byte 5 in `xfer_data[47:40]` and bytes 11, 12, 13, 14 and 15 in `xfer_data[39:32]`, `[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R6: When the twelfth data byte of a violation-free line completes, `davn_n` goes low and `xfer_data` takes the new label one clock after the decoder registers that byte, while the gate is still high.
- R7: `davn_n` returns to 1 on the clock after `line_gate` rises.
- R8: If `host_busy` is high in the cycle the line completes, the transfer register is not updated and `davn_n` stays high.
- R9: If `line_gate` falls before the twelfth data byte, the line is abandoned: `xfer_data` is unchanged, `davn_n` stays high, and the next line decodes normally.
- R10: Samples are taken only on cycles where both `samp_en` and `line_gate` are high. Sample-enable pulses while the gate is low, and data changes between enables, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_gate | input | 1 | High during the line-16 data window |
| samp_en | input | 1 | One-cycle strobe, two per data bit |
| sdata | input | 1 | Sliced video data bit |
| host_busy | input | 1 | High while the host reads the transfer register |
| davn_n | output | 1 | Data-available flag, active low |
| xfer_data | output | 48 | Committed label bytes, byte 5 first |

## Verification
The assertions assume three things about the inputs. First, `samp_en` is a single-cycle pulse with at least one idle clock between pulses, so that the registered start-pattern detection is seen before the next half-bit arrives. Second, `line_gate` rises once per line and never on a cycle that also carries a sample. Third, a line is never finished in the same cycle as the next line begins. The stimulus keeps to these rules by spacing strobes four clocks apart and raising the gate two clocks before the first strobe. It also inverts `sdata` on every clock between strobes, so any sampling outside the strobe would corrupt the label.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int BYTE_W          = 8;
    localparam int N_DATA          = 12;
    localparam int IDX_W           = $clog2(N_DATA);
    localparam int FIRST_LINE_BYTE = 4;
    localparam int ID_LINE_BYTE    = 5;
    localparam int LABEL_FIRST     = 11;
    localparam int N_LABEL         = 5;
    localparam int N_SLOTS         = N_LABEL + 1;
    localparam int SLOT_W          = $clog2(N_SLOTS);
    localparam int XFER_W          = N_SLOTS * BYTE_W;
    localparam int SYNC_BITS       = 24;
    localparam logic [SYNC_BITS-1:0] SYNC_WORD = 24'hAAAA59;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA,
        ST_DONE
    } dfr_state_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } byte_evt_t;

    typedef struct packed {
        logic viol;
        logic bit_val;
    } symbol_t;

    // First half 1 then 0 -> 1, 0 then 1 -> 0, equal halves -> violation
    function automatic symbol_t biphase_decode(input logic first_half, input logic second_half);
        symbol_t s;
        s.viol    = (first_half == second_half);
        s.bit_val = first_half;
        return s;
    endfunction

    // Map a data-byte index to its label slot; MSB of the result flags a hit
    function automatic logic [SLOT_W:0] slot_of(input logic [IDX_W-1:0] k);
        int lb;
        lb = int'(k) + FIRST_LINE_BYTE;
        if (lb == ID_LINE_BYTE)
            return {1'b1, SLOT_W'(0)};
        if (lb >= LABEL_FIRST && lb < LABEL_FIRST + N_LABEL)
            return {1'b1, SLOT_W'(lb - LABEL_FIRST + 1)};
        return '0;
    endfunction

endpackage

// File: rtl/vps_sync_hunt.sv
module vps_sync_hunt #(
    parameter int                SYNC_W   = 24,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 24'hAAAA59
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  logic sdata,
    output logic found
);

    logic [SYNC_W-1:0] window_q;
    logic [SYNC_W-1:0] window_d;

    assign window_d = {window_q[SYNC_W-2:0], sdata};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            window_q <= '0;
            found    <= 1'b0;
        end else begin
            found <= 1'b0;
            if (shift_en) begin
                window_q <= window_d;
                found    <= (window_d == SYNC_PAT);
            end
        end
    end

endmodule

// File: rtl/vps_biphase_deframer.sv
module vps_biphase_deframer
    import vps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_start,
    input  logic      gate,
    input  logic      samp_en,
    input  logic      sdata,
    input  logic      sync_found,
    output logic      hunting,
    output byte_evt_t byte_evt,
    output logic      line_done,
    output logic      line_err
);

    dfr_state_e        state_q;
    logic              half_q;
    logic              first_q;
    logic [2:0]        bitcnt_q;
    logic [IDX_W-1:0]  bytecnt_q;
    logic [BYTE_W-2:0] acc_q;
    symbol_t           sym;

    assign sym     = biphase_decode(first_q, sdata);
    assign hunting = (state_q == ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            half_q    <= 1'b0;
            first_q   <= 1'b0;
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
            acc_q     <= '0;
            byte_evt  <= '0;
            line_done <= 1'b0;
            line_err  <= 1'b0;
        end else begin
            byte_evt.valid <= 1'b0;
            line_done      <= 1'b0;
            if (line_start) begin
                state_q   <= ST_HUNT;
                half_q    <= 1'b0;
                bitcnt_q  <= '0;
                bytecnt_q <= '0;
                line_err  <= 1'b0;
            end else if (!gate) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_HUNT: begin
                        if (sync_found)
                            state_q <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (samp_en) begin
                            if (!half_q) begin
                                first_q <= sdata;
                                half_q  <= 1'b1;
                            end else begin
                                half_q   <= 1'b0;
                                acc_q    <= {acc_q[BYTE_W-3:0], sym.bit_val};
                                bitcnt_q <= bitcnt_q + 3'd1;
                                if (sym.viol)
                                    line_err <= 1'b1;
                                if (bitcnt_q == 3'd7) begin
                                    byte_evt.valid <= 1'b1;
                                    byte_evt.idx   <= bytecnt_q;
                                    byte_evt.data  <= {acc_q, sym.bit_val};
                                    bytecnt_q      <= bytecnt_q + 1'b1;
                                    if (bytecnt_q == IDX_W'(N_DATA - 1)) begin
                                        state_q   <= ST_DONE;
                                        line_done <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/vps_label_store.sv
module vps_label_store
    import vps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  byte_evt_t         byte_evt,
    input  logic              line_done,
    input  logic              line_err,
    input  logic              host_busy,
    output logic              davn_n,
    output logic [XFER_W-1:0] xfer_data
);

    logic [BYTE_W-1:0] shadow_q [N_SLOTS];
    logic [BYTE_W-1:0] shadow_d [N_SLOTS];
    logic [BYTE_W-1:0] xfer_q   [N_SLOTS];
    logic [SLOT_W:0]   hit;

    always_comb begin
        shadow_d = shadow_q;
        hit      = slot_of(byte_evt.idx);
        if (byte_evt.valid && hit[SLOT_W])
            shadow_d[hit[SLOT_W-1:0]] = byte_evt.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '{default: '0};
            xfer_q   <= '{default: '0};
            davn_n   <= 1'b1;
        end else begin
            shadow_q <= shadow_d;
            if (line_start) begin
                davn_n <= 1'b1;
            end else if (line_done && !line_err && !host_busy) begin
                davn_n <= 1'b0;
                xfer_q <= shadow_d;
            end
        end
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_out
        assign xfer_data[(N_SLOTS-1-s)*BYTE_W +: BYTE_W] = xfer_q[s];
    end

endmodule

// File: rtl/vps_line_decoder.sv
module vps_line_decoder
    import vps_pkg::*;
#(
    parameter int                SYNC_W   = SYNC_BITS,
    parameter logic [SYNC_W-1:0] SYNC_PAT = SYNC_WORD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_gate,
    input  logic              samp_en,
    input  logic              sdata,
    input  logic              host_busy,
    output logic              davn_n,
    output logic [XFER_W-1:0] xfer_data
);

    logic             gate_q;
    logic             line_start;
    logic             hunting;
    logic             sync_found;
    logic             line_done;
    logic             line_err;
    byte_evt_t        byte_evt;
    logic             evt_valid;
    logic [IDX_W-1:0] evt_idx;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= line_gate;
    end

    assign line_start = line_gate && !gate_q;
    assign evt_valid  = byte_evt.valid;
    assign evt_idx    = byte_evt.idx;

    vps_sync_hunt #(
        .SYNC_W  (SYNC_W),
        .SYNC_PAT(SYNC_PAT)
    ) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .clear   (line_start),
        .shift_en(samp_en && line_gate && hunting),
        .sdata   (sdata),
        .found   (sync_found)
    );

    vps_biphase_deframer u_dfr (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .gate      (line_gate),
        .samp_en   (samp_en),
        .sdata     (sdata),
        .sync_found(sync_found),
        .hunting   (hunting),
        .byte_evt  (byte_evt),
        .line_done (line_done),
        .line_err  (line_err)
    );

    vps_label_store u_store (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .byte_evt  (byte_evt),
        .line_done (line_done),
        .line_err  (line_err),
        .host_busy (host_busy),
        .davn_n    (davn_n),
        .xfer_data (xfer_data)
    );

endmodule

// File: rtl/vps_line_decoder_chk.sv
module vps_line_decoder_chk
    import vps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_gate,
    input logic              host_busy,
    input logic              davn_n,
    input logic [XFER_W-1:0] xfer_data,
    input logic              line_start,
    input logic              line_done,
    input logic              line_err,
    input logic              evt_valid,
    input logic [IDX_W-1:0]  evt_idx
);

    a_r7_release_at_line_start: assert property (@(posedge clk) disable iff (rst)
        line_start |=> davn_n);

    a_r6_flag_only_on_clean_done: assert property (@(posedge clk) disable iff (rst)
        $fell(davn_n) |-> $past(line_done && !line_err && !host_busy));

    a_r8_busy_freezes_transfer: assert property (@(posedge clk) disable iff (rst)
        $past(host_busy) |-> $stable(xfer_data));

    a_r5_transfer_moves_with_flag: assert property (@(posedge clk) disable iff (rst)
        !$fell(davn_n) |-> $stable(xfer_data));

    a_r4_error_sticky_in_line: assert property (@(posedge clk) disable iff (rst)
        $fell(line_err) |-> $past(line_start));

    a_r2_byte_index_in_range: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_idx < IDX_W'(N_DATA)));

    a_r10_gate_qualifies_bytes: assert property (@(posedge clk) disable iff (rst)
        !line_gate |=> !evt_valid);

endmodule

bind vps_line_decoder vps_line_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_gate (line_gate),
    .host_busy (host_busy),
    .davn_n    (davn_n),
    .xfer_data (xfer_data),
    .line_start(line_start),
    .line_done (line_done),
    .line_err  (line_err),
    .evt_valid (evt_valid),
    .evt_idx   (evt_idx)
);

// File: tb/vps_line_decoder_tb.sv
module vps_line_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] START_PAT = 24'hAAAA59;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_gate = 1'b0;
    logic        samp_en = 1'b0;
    logic        sdata = 1'b0;
    logic        host_busy = 1'b0;
    logic        davn_n;
    logic [47:0] xfer_data;

    int errors = 0;
    int checks = 0;
    logic [47:0] last_label = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vps_line_decoder u_dut (
        .clk      (clk),
        .rst      (rst),
        .line_gate(line_gate),
        .samp_en  (samp_en),
        .sdata    (sdata),
        .host_busy(host_busy),
        .davn_n   (davn_n),
        .xfer_data(xfer_data)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One half-bit sample, data inverted on the idle clocks (R10 noise)
    task automatic half(input logic b);
        @(negedge clk); sdata = b; samp_en = 1'b1;
        @(negedge clk); samp_en = 1'b0; sdata = ~b;
        @(negedge clk); sdata = b;
        @(negedge clk); sdata = ~b;
    endtask

    task automatic send_bit(input logic b, input logic viol);
        half(b);
        half(viol ? b : ~b);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic viol);
        for (int i = 7; i >= 0; i--)
            send_bit(v[i], viol && (i == 7));
    endtask

    task automatic send_sync();
        for (int i = 0; i < 8; i++) half(i % 2 == 0);
        for (int i = 23; i >= 0; i--) half(START_PAT[i]);
    endtask

    task automatic line_begin();
        @(negedge clk); line_gate = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic line_end();
        repeat (4) @(negedge clk);
        line_gate = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [47:0] label_of(input logic [7:0] b [12]);
        return {b[1], b[7], b[8], b[9], b[10], b[11]};
    endfunction

    task automatic send_line(input logic [7:0] b [12], input int viol_at, input logic sync);
        line_begin();
        if (sync) send_sync();
        else for (int i = 0; i < 32; i++) half(i % 2 == 0);
        for (int k = 0; k < 12; k++) send_byte(b[k], k == viol_at);
    endtask

    task automatic fill(output logic [7:0] b [12], input logic [7:0] seed);
        for (int k = 0; k < 12; k++) b[k] = seed ^ 8'(k * 37);
    endtask

    task automatic t_reset();
        check("R1 davn_n", {47'd0, davn_n}, 48'd1);
        check("R1 xfer_data", xfer_data, 48'd0);
    endtask

    task automatic t_good(input logic [7:0] seed);
        logic [7:0] b [12];
        fill(b, seed);
        b[1] = 8'h80; b[7] = 8'h01;
        send_line(b, -1, 1'b1);
        check("R6 davn_n low in line", {47'd0, davn_n}, 48'd0);
        check("R5 R3 label bytes", xfer_data, label_of(b));
        last_label = label_of(b);
        line_end();
        check("R6 davn_n held after gate", {47'd0, davn_n}, 48'd0);
    endtask

    task automatic t_release();
        line_begin();
        check("R7 davn_n released", {47'd0, davn_n}, 48'd1);
        line_end();
    endtask

    task automatic t_violation(input int at);
        logic [7:0] b [12];
        fill(b, 8'h3C);
        send_line(b, at, 1'b1);
        check("R4 davn_n stays high", {47'd0, davn_n}, 48'd1);
        check("R4 xfer kept", xfer_data, last_label);
        line_end();
    endtask

    task automatic t_busy();
        logic [7:0] b [12];
        fill(b, 8'hC3);
        host_busy = 1'b1;
        send_line(b, -1, 1'b1);
        check("R8 davn_n stays high", {47'd0, davn_n}, 48'd1);
        check("R8 xfer kept", xfer_data, last_label);
        line_end();
        host_busy = 1'b0;
    endtask

    task automatic t_abandon();
        logic [7:0] b [12];
        fill(b, 8'h77);
        line_begin();
        send_sync();
        for (int k = 0; k < 3; k++) send_byte(b[k], 1'b0);
        line_gate = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 davn_n high", {47'd0, davn_n}, 48'd1);
        check("R9 xfer kept", xfer_data, last_label);
    endtask

    task automatic t_nosync();
        logic [7:0] b [12];
        fill(b, 8'h99);
        send_line(b, -1, 1'b0);
        check("R2 no start pattern davn_n", {47'd0, davn_n}, 48'd1);
        check("R2 no start pattern xfer", xfer_data, last_label);
        line_end();
    endtask

    task automatic t_gated_out();
        logic [7:0] b [12];
        fill(b, 8'h5A);
        send_sync();
        send_line(b, -1, 1'b0);
        check("R10 enables with gate low ignored", {47'd0, davn_n}, 48'd1);
        check("R10 xfer kept", xfer_data, last_label);
        line_end();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good(8'hA5);
        t_release();
        t_good(8'h1E);
        t_violation(3);
        t_violation(11);
        t_busy();
        t_abandon();
        t_good(8'h62);
        t_nosync();
        t_gated_out();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule